// File: doc/BRIEF.md
# Dual-Bucket Cell Rate Policer

This block checks every arriving cell of a connection against that connection's traffic contract. It runs two independent rate-conformance tests, both in the virtual scheduling form, one after the other. Each test, called a bucket here, holds its own increment I, its own limit L and its own theoretical arrival time (TAT). Time is a free-running count of cell slots, and `tick` advances it. The parameters for each connection sit in a small register table indexed by connection number. A single write port loads the whole entry of one connection.

For each cell the block returns one verdict one cycle later: pass, tag or drop. A tagged cell leaves with its CLP bit set to 1. Each bucket has its own cell scope (all cells, or CLP=0 cells only) and its own action on a violation: monitor, tag or drop. Bucket 0 is tested first, and a cell it tags reaches bucket 1 as a CLP=1 cell. Two saturating counters record how many violations each bucket has seen, summed over all connections. Policing can be switched off for all connections at once or for a single connection.

Top module: `dual_gcra_policer`

## Requirements
- R1: A cell arriving at slot time ta conforms to a bucket when TAT - ta <= L. A conforming cell that is not dropped moves that bucket's TAT to max(ta, TAT) + I.
- R2: A cell that does not conform leaves the TAT of the bucket it violated unchanged.
- R3: The bucket mode is 3 bits. Bits [1:0] give the action on a violation: 0 monitor (the cell passes and is counted), 1 tag, 2 drop, 3 bucket unused. `res_act` reports 0 for pass, 1 for tag and 2 for drop, and never reports 3. When the verdict is tag, `res_clp` is 1.
- R4: Mode bit [2] set makes a bucket test CLP=0 cells only. A CLP=1 cell is then not tested by that bucket and does not change its TAT.
- R5: When one bucket flags drop and the other flags tag, the verdict is drop. Bucket 1 sees a cell that bucket 0 tagged as CLP=1. `res_clp` is the input CLP ORed with any tag flag, and this holds for dropped cells too.
- R6: A cell with a drop verdict does not update the TAT of either bucket, even a bucket it conformed to.
- R7: When `glb_en` is 0, or the connection's enable bit is 0, every cell passes with its CLP unchanged. Neither TAT moves and neither counter moves.
- R8: `res_vld` is high for exactly the cycle after each cycle with `cell_vld` high, and the verdict outputs are valid in that cycle.
- R9: `viol0` and `viol1` each add one for every policed cell that violates bucket 0 or bucket 1 respectively, under any action. Each saturates at its maximum value.
- R10: After reset every connection is disabled and both counters read 0. A table write loads the increment, limit, mode and enable of both buckets and sets both TATs to the current slot time.
- R11: The TAT comparison stays correct when the slot time counter wraps past its maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advance the slot time by one |
| glb_en | input | 1 | Policing enable for all connections |
| cfg_we | input | 1 | Write one table entry |
| cfg_conn | input | CW | Connection being written |
| cfg_en | input | 1 | Per-connection policing enable |
| cfg_inc0 | input | IW | Bucket 0 increment I |
| cfg_lim0 | input | IW | Bucket 0 limit L |
| cfg_mode0 | input | 3 | Bucket 0 scope and action |
| cfg_inc1 | input | IW | Bucket 1 increment I |
| cfg_lim1 | input | IW | Bucket 1 limit L |
| cfg_mode1 | input | 3 | Bucket 1 scope and action |
| cell_vld | input | 1 | A cell arrives this cycle |
| cell_conn | input | CW | Connection number of the cell |
| cell_clp | input | 1 | CLP bit of the cell |
| res_vld | output | 1 | Verdict valid |
| res_act | output | 2 | Verdict: 0 pass, 1 tag, 2 drop |
| res_clp | output | 1 | Outgoing CLP bit |
| viol0 | output | CNTW | Violation count of bucket 0 |
| viol1 | output | CNTW | Violation count of bucket 1 |

## Verification
Four connections are set up with different mode pairs: a single dropping bucket, a tagging bucket followed by a CLP0-only dropping bucket, two all-cell buckets that tag and drop, and a monitoring bucket. Cells then arrive early, exactly on TAT, inside the limit and long after TAT. Early arrivals that are followed by an on-time cell show whether a violation wrongly moved the TAT. A bucket-0 pass paired with a bucket-1 drop shows whether a dropped cell leaks an update. CLP=1 cells sent to CLP0-only buckets separate the scope rules from the tag carry-over. Directed cases cover both kinds of disable, counter saturation, rewriting a table entry, and a burst that crosses the wrap of the slot counter, where an unsigned compare would admit a cell that should be dropped.

// File: rtl/dual_gcra_policer.sv
module dual_gcra_policer #(
  parameter int NCONN = 16,
  parameter int TW    = 24,
  parameter int CNTW  = 16,
  localparam int CW   = (NCONN > 1) ? $clog2(NCONN) : 1,
  localparam int IW   = TW - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            glb_en,
  input  logic            cfg_we,
  input  logic [CW-1:0]   cfg_conn,
  input  logic            cfg_en,
  input  logic [IW-1:0]   cfg_inc0,
  input  logic [IW-1:0]   cfg_lim0,
  input  logic [2:0]      cfg_mode0,
  input  logic [IW-1:0]   cfg_inc1,
  input  logic [IW-1:0]   cfg_lim1,
  input  logic [2:0]      cfg_mode1,
  input  logic            cell_vld,
  input  logic [CW-1:0]   cell_conn,
  input  logic            cell_clp,
  output logic            res_vld,
  output logic [1:0]      res_act,
  output logic            res_clp,
  output logic [CNTW-1:0] viol0,
  output logic [CNTW-1:0] viol1
);

  localparam logic [CNTW-1:0] CMAX = {CNTW{1'b1}};

  logic [TW-1:0]    tnow;
  logic [NCONN-1:0] en_q;
  logic [IW-1:0]    inc_q  [2][NCONN];
  logic [IW-1:0]    lim_q  [2][NCONN];
  logic [2:0]       mode_q [2][NCONN];
  logic [TW-1:0]    tat_q  [2][NCONN];

  // returns {applies, conforms, next_tat}
  function automatic logic [TW+1:0] judge(input logic [TW-1:0] tat, input logic [IW-1:0] inc,
                                          input logic [IW-1:0] lim, input logic [2:0] mode,
                                          input logic clp, input logic [TW-1:0] ta);
    logic [TW-1:0] diff;
    logic [TW-1:0] base;
    logic          app;
    logic          conf;
    diff = tat - ta;
    app  = (mode[1:0] != 2'd3) && !(mode[2] && clp);
    conf = $signed(diff) <= $signed({2'b00, lim});
    base = diff[TW-1] ? ta : tat;
    return {app, conf, base + {2'b00, inc}};
  endfunction

  logic [TW+1:0] j0, j1;
  logic [2:0]    m0, m1;
  logic          flag0, flag1, tag0, tag1, drop0, drop1;
  logic          active, any_drop, any_tag;

  assign m0    = mode_q[0][cell_conn];
  assign m1    = mode_q[1][cell_conn];
  assign j0    = judge(tat_q[0][cell_conn], inc_q[0][cell_conn], lim_q[0][cell_conn], m0, cell_clp, tnow);
  assign flag0 = j0[TW+1] & ~j0[TW];
  assign tag0  = flag0 & (m0[1:0] == 2'd1);
  assign drop0 = flag0 & (m0[1:0] == 2'd2);
  assign j1    = judge(tat_q[1][cell_conn], inc_q[1][cell_conn], lim_q[1][cell_conn], m1,
                       cell_clp | tag0, tnow);
  assign flag1 = j1[TW+1] & ~j1[TW];
  assign tag1  = flag1 & (m1[1:0] == 2'd1);
  assign drop1 = flag1 & (m1[1:0] == 2'd2);

  assign active   = cell_vld & glb_en & en_q[cell_conn];
  assign any_drop = drop0 | drop1;
  assign any_tag  = tag0 | tag1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tnow    <= '0;
      en_q    <= '0;
      res_vld <= 1'b0;
      res_act <= 2'd0;
      res_clp <= 1'b0;
      viol0   <= '0;
      viol1   <= '0;
      for (int b = 0; b < 2; b++) begin
        for (int c = 0; c < NCONN; c++) begin
          inc_q[b][c]  <= '0;
          lim_q[b][c]  <= '0;
          mode_q[b][c] <= 3'd3;
          tat_q[b][c]  <= '0;
        end
      end
    end else begin
      if (tick) tnow <= tnow + 1'b1;
      res_vld <= cell_vld;
      res_act <= !active ? 2'd0 : any_drop ? 2'd2 : any_tag ? 2'd1 : 2'd0;
      res_clp <= cell_clp | (active & any_tag);
      if (active) begin
        if (flag0 && viol0 != CMAX) viol0 <= viol0 + 1'b1;
        if (flag1 && viol1 != CMAX) viol1 <= viol1 + 1'b1;
        if (!any_drop && j0[TW+1] && j0[TW]) tat_q[0][cell_conn] <= j0[TW-1:0];
        if (!any_drop && j1[TW+1] && j1[TW]) tat_q[1][cell_conn] <= j1[TW-1:0];
      end
      if (cfg_we) begin
        en_q[cfg_conn]      <= cfg_en;
        inc_q[0][cfg_conn]  <= cfg_inc0;
        lim_q[0][cfg_conn]  <= cfg_lim0;
        mode_q[0][cfg_conn] <= cfg_mode0;
        inc_q[1][cfg_conn]  <= cfg_inc1;
        lim_q[1][cfg_conn]  <= cfg_lim1;
        mode_q[1][cfg_conn] <= cfg_mode1;
        tat_q[0][cfg_conn]  <= tnow;
        tat_q[1][cfg_conn]  <= tnow;
      end
    end
  end

endmodule

module dual_gcra_policer_chk #(
  parameter int CNTW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            glb_en,
  input logic            cell_vld,
  input logic            cell_clp,
  input logic            res_vld,
  input logic [1:0]      res_act,
  input logic            res_clp,
  input logic [CNTW-1:0] viol0,
  input logic [CNTW-1:0] viol1
);

  // R8
  res_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) cell_vld |=> res_vld);
  // R8
  res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !cell_vld |=> !res_vld);
  // R3
  act_code_chk: assert property (@(posedge clk) disable iff (!rst_n) res_vld |-> res_act != 2'd3);
  // R3
  tag_clp_chk: assert property (@(posedge clk) disable iff (!rst_n) (res_vld && res_act == 2'd1) |-> res_clp);
  // R7
  off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_vld && !glb_en) |=> (res_act == 2'd0 && res_clp == $past(cell_clp)));
  // R7
  off_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> ($stable(viol0) && $stable(viol1)));
  // R9
  viol_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((viol0 == $past(viol0) || viol0 == $past(viol0) + 1'b1) &&
              (viol1 == $past(viol1) || viol1 == $past(viol1) + 1'b1)));

endmodule

bind dual_gcra_policer dual_gcra_policer_chk #(.CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cell_vld(cell_vld), .cell_clp(cell_clp),
  .res_vld(res_vld), .res_act(res_act), .res_clp(res_clp), .viol0(viol0), .viol1(viol1)
);

// File: tb/dual_gcra_policer_bench.sv
`timescale 1ns/1ps
module dual_gcra_policer_bench;
  localparam int NCONN = 8;
  localparam int TW    = 10;
  localparam int CNTW  = 4;
  localparam int CW    = 3;
  localparam int IW    = TW - 2;

  logic clk = 0, rst_n = 0, tick = 0, glb_en = 1, cfg_we = 0, cfg_en = 0;
  logic [CW-1:0] cfg_conn = 0, cell_conn = 0;
  logic [IW-1:0] cfg_inc0 = 0, cfg_lim0 = 0, cfg_inc1 = 0, cfg_lim1 = 0;
  logic [2:0] cfg_mode0 = 3, cfg_mode1 = 3;
  logic cell_vld = 0, cell_clp = 0;
  logic res_vld, res_clp;
  logic [1:0] res_act;
  logic [CNTW-1:0] viol0, viol1;
  int total = 0, bad = 0;
  bit done = 0;

  dual_gcra_policer #(.NCONN(NCONN), .TW(TW), .CNTW(CNTW)) u_dual_gcra_policer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .glb_en(glb_en), .cfg_we(cfg_we),
    .cfg_conn(cfg_conn), .cfg_en(cfg_en), .cfg_inc0(cfg_inc0), .cfg_lim0(cfg_lim0),
    .cfg_mode0(cfg_mode0), .cfg_inc1(cfg_inc1), .cfg_lim1(cfg_lim1), .cfg_mode1(cfg_mode1),
    .cell_vld(cell_vld), .cell_conn(cell_conn), .cell_clp(cell_clp),
    .res_vld(res_vld), .res_act(res_act), .res_clp(res_clp), .viol0(viol0), .viol1(viol1));

  always #10 clk = ~clk;

  // adv[14:7] conn[6:4] clp[3] act[2:1] out_clp[0]
  localparam logic [14:0] VEC [0:14] = '{
    {8'd0,  3'd0, 1'b0, 2'd0, 1'b0},
    {8'd2,  3'd0, 1'b0, 2'd2, 1'b0},
    {8'd2,  3'd0, 1'b0, 2'd0, 1'b0},
    {8'd0,  3'd0, 1'b1, 2'd2, 1'b1},
    {8'd10, 3'd0, 1'b0, 2'd0, 1'b0},
    {8'd0,  3'd1, 1'b0, 2'd0, 1'b0},
    {8'd1,  3'd1, 1'b0, 2'd1, 1'b1},
    {8'd1,  3'd1, 1'b0, 2'd2, 1'b0},
    {8'd0,  3'd1, 1'b1, 2'd0, 1'b1},
    {8'd0,  3'd1, 1'b0, 2'd1, 1'b1},
    {8'd0,  3'd2, 1'b0, 2'd0, 1'b0},
    {8'd0,  3'd2, 1'b0, 2'd2, 1'b1},
    {8'd0,  3'd3, 1'b0, 2'd0, 1'b0},
    {8'd0,  3'd3, 1'b0, 2'd0, 1'b0},
    {8'd4,  3'd3, 1'b0, 2'd0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1;
      repeat (n) @(negedge clk);
      tick = 0;
    end
  endtask

  task automatic cfg(input int c, input bit en, input int i0, input int l0, input int m0,
                     input int i1, input int l1, input int m1);
    @(negedge clk);
    cfg_we = 1; cfg_conn = CW'(c); cfg_en = en;
    cfg_inc0 = IW'(i0); cfg_lim0 = IW'(l0); cfg_mode0 = 3'(m0);
    cfg_inc1 = IW'(i1); cfg_lim1 = IW'(l1); cfg_mode1 = 3'(m1);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input int c, input bit clp, input string req, input int ea, input int ec);
    @(negedge clk);
    cell_vld = 1; cell_conn = CW'(c); cell_clp = clp;
    @(negedge clk);
    cell_vld = 0;
    check("R8", int'(res_vld), 1);
    check(req, int'(res_act), ea);
    check(req, int'(res_clp), ec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10", int'(res_vld), 0);
    check("R10", int'(viol0), 0);
    check("R10", int'(viol1), 0);
    send(0, 1'b0, "R10", 0, 0);
    @(negedge clk);
    check("R8", int'(res_vld), 0);

    cfg(0, 1, 4, 0, 3'b010, 0, 0, 3'b011);
    cfg(1, 1, 4, 2, 3'b001, 8, 0, 3'b110);
    cfg(2, 1, 4, 0, 3'b001, 4, 0, 3'b010);
    cfg(3, 1, 4, 0, 3'b000, 0, 0, 3'b011);
    cfg(4, 0, 100, 0, 3'b010, 0, 0, 3'b011);

    // R1 R2 R3 R4 R5 R6 table walk
    for (int k = 0; k < 15; k++) begin
      ticks(int'(VEC[k][14:7]));
      send(int'(VEC[k][6:4]), VEC[k][3], "R1/R2/R3/R4/R5/R6 vector", int'(VEC[k][2:1]), int'(VEC[k][0]));
    end
    check("R9", int'(viol0), 6);
    check("R9", int'(viol1), 2);

    // R7 per-connection off
    send(4, 1'b1, "R7", 0, 1);
    send(4, 1'b1, "R7", 0, 1);
    // R7 global off, TAT untouched
    glb_en = 0;
    send(0, 1'b0, "R7", 0, 0);
    send(0, 1'b1, "R7", 0, 1);
    glb_en = 1;
    send(0, 1'b0, "R7", 0, 0);
    check("R7", int'(viol0), 6);

    // R9 saturation
    for (int k = 0; k < 12; k++) send(0, 1'b0, "R9", 2, 0);
    check("R9", int'(viol0), 15);
    check("R9", int'(viol1), 2);

    // R10 rewrite resets TAT to now
    cfg(0, 1, 4, 0, 3'b010, 0, 0, 3'b011);
    send(0, 1'b0, "R10", 0, 0);

    // R11 wrap of slot time (now 20 -> 1020)
    ticks(1000);
    cfg(5, 1, 16, 0, 3'b010, 0, 0, 3'b011);
    send(5, 1'b0, "R11", 0, 0);
    ticks(2);
    send(5, 1'b0, "R11", 2, 0);
    ticks(14);
    send(5, 1'b0, "R11", 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule